// File: doc/BRIEF.md
# Dual Addressable Scan Latch Port

This block is a write-only output port that holds the scan state of a keyboard and LED matrix. It owns two banks of eight single-bit outputs: one bank sinks the LED matrix columns, the other drives the switch matrix rows. Every CPU write strobe carries one byte. The low nibble addresses one switch-row output and gives it a value, and the high nibble does the same for one LED-sink output. Only the two addressed outputs change. Every other output keeps its value.

The top output of the switch-row bank is wired back as a common clear for both banks. Writing the low nibble as address 7 with data 1 (for example byte 0x0F) raises that output for one clock. On the next edge it wipes all sixteen outputs, including itself, so the clear ends by itself. Software issues this write at boot to put the scan state into a known condition. A small two-state controller tracks this. State RUN accepts writes. The transition RUN to CLEAR is taken on a write whose switch-row field is address 7 with data 1. In state CLEAR, both banks are forced low and any write is ignored. The transition CLEAR to RUN is taken unconditionally on the next clock.

Top module: `scan_latch_port`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, all of `led_sink` and `key_drive` are 0.
- R2: A write (`wr_en`=1 on a clock edge in state RUN) sets `key_drive[wr_data[2:0]]` to `wr_data[3]` after that edge.
- R3: The same write sets `led_sink[wr_data[6:4]]` to `wr_data[7]` after that edge.
- R4: On a write, every output other than the two addressed ones keeps its previous value.
- R5: With `wr_en`=0 in state RUN, all sixteen outputs hold their values.
- R6: A write with `wr_data[2:0]`=7 and `wr_data[3]`=1 makes `key_drive[7]` read 1 in the cycle after the write. On the edge that follows, all sixteen outputs become 0.
- R7: A write presented in the clearing cycle (while `key_drive[7]` is 1) has no effect: after that edge all outputs are 0.
- R8: A write with `wr_data[6:4]`=7 and `wr_data[7]`=1 sets `led_sink[7]` and does not start a clear. Other outputs are untouched, except the one addressed by the low nibble.
- R9: A write with `wr_data[2:0]`=7 and `wr_data[3]`=0 only drives `key_drive[7]` to 0 and starts no clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Port write strobe, sampled on the clock edge |
| wr_data | input | 8 | Written byte: [3] switch data, [2:0] switch address, [7] LED data, [6:4] LED address |
| led_sink | output | 8 | LED matrix sink outputs |
| key_drive | output | 8 | Switch matrix drive outputs; bit 7 is the self-clear |

## Verification
The hardest case to reach is a write that lands in the one clock where the self-clear is pending. It must be ignored, but it would otherwise look like an ordinary update. The driver reaches this case by issuing a second strobe on the clock directly after byte 0x0F. It does this with both nibbles addressing outputs that are set, so any leak shows as a surviving 1. The scoreboard model also covers two near-misses of the clear pattern: LED address 7 with data 1, and switch address 7 with data 0. In each of these, the outputs set earlier must survive.

// File: rtl/scan_latch_pkg.sv
package scan_latch_pkg;

    // Controller states for the self-clearing path
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } clr_state_t;

endpackage

// File: rtl/scan_field_split.sv
// Extracts one {data, address} field from the written byte.
module scan_field_split #(
    parameter int ADDR_W = 3,
    parameter int OFFSET = 0,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr,
    output logic              bit_val
);
    always_comb begin
        addr    = byte_in[OFFSET +: ADDR_W];
        bit_val = byte_in[OFFSET + ADDR_W];
    end
endmodule

// File: rtl/scan_addr_latch.sv
// Addressable bit latch: one output updated per strobe, synchronous clear dominates.
module scan_addr_latch #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit_val,
    output logic [N_OUT-1:0]  q
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_cell
        logic hit;
        assign hit = upd && (addr == ADDR_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (clr) begin
                q[i] <= 1'b0;
            end else if (hit) begin
                q[i] <= bit_val;
            end
        end
    end
endmodule

// File: rtl/scan_clear_ctrl.sv
// Two-state controller that sequences the self-clear pulse.
module scan_clear_ctrl
    import scan_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int CLR_IDX = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] key_addr,
    input  logic              key_bit,
    output logic              clr,
    output logic              upd
);
    clr_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (wr_en && key_bit && key_addr == ADDR_W'(CLR_IDX))
                          state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        upd = 1'b0;
        unique case (state)
            ST_RUN:   upd = wr_en;
            ST_CLEAR: clr = 1'b1;
            default:  clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/scan_latch_port.sv
module scan_latch_port #(
    parameter int ADDR_W = 3,
    localparam int FIELD_W = ADDR_W + 1,
    localparam int BYTE_W  = 2 * FIELD_W,
    localparam int N_OUT   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [N_OUT-1:0]  led_sink,
    output logic [N_OUT-1:0]  key_drive
);
    logic [ADDR_W-1:0] key_addr, led_addr;
    logic              key_bit, led_bit;
    logic              clr, upd;

    scan_field_split #(.ADDR_W(ADDR_W), .OFFSET(0), .BYTE_W(BYTE_W)) u_key_fld (
        .byte_in(wr_data), .addr(key_addr), .bit_val(key_bit));

    scan_field_split #(.ADDR_W(ADDR_W), .OFFSET(FIELD_W), .BYTE_W(BYTE_W)) u_led_fld (
        .byte_in(wr_data), .addr(led_addr), .bit_val(led_bit));

    scan_clear_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .key_addr(key_addr), .key_bit(key_bit),
        .clr(clr), .upd(upd));

    scan_addr_latch #(.ADDR_W(ADDR_W)) u_key (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd),
        .addr(key_addr), .bit_val(key_bit), .q(key_drive));

    scan_addr_latch #(.ADDR_W(ADDR_W)) u_led (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd),
        .addr(led_addr), .bit_val(led_bit), .q(led_sink));
endmodule

// File: rtl/scan_latch_port_chk.sv
module scan_latch_port_chk #(
    parameter int ADDR_W = 3,
    localparam int FIELD_W = ADDR_W + 1,
    localparam int BYTE_W  = 2 * FIELD_W,
    localparam int N_OUT   = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic [N_OUT-1:0]  led_sink,
    input logic [N_OUT-1:0]  key_drive
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_low_chk: assert (led_sink == '0 && key_drive == '0);
        end
    end

    // R2
    key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !key_drive[N_OUT-1] |=>
        key_drive[$past(wr_data[ADDR_W-1:0])] == $past(wr_data[ADDR_W]));

    // R3
    led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !key_drive[N_OUT-1] |=>
        led_sink[$past(wr_data[FIELD_W +: ADDR_W])] == $past(wr_data[BYTE_W-1]));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !key_drive[N_OUT-1] |=> $stable(led_sink) && $stable(key_drive));

    // R6
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_drive[N_OUT-1] |=> led_sink == '0 && key_drive == '0);

    // R7
    clear_ignores_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_drive[N_OUT-1] && wr_en |=> $countones({led_sink, key_drive}) == 0);

    // R8
    led_top_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !key_drive[N_OUT-1] && !wr_data[ADDR_W] &&
        wr_data[BYTE_W-1:FIELD_W] == '1 |=> led_sink[N_OUT-1] && !key_drive[N_OUT-1]);
endmodule

bind scan_latch_port scan_latch_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .led_sink(led_sink), .key_drive(key_drive));

// File: tb/sim_scan_latch_port.sv
module sim_scan_latch_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] led_sink, key_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] led;
        logic [7:0] key;
        string      tag;
    } exp_t;

    exp_t q[$];

    logic [7:0] m_led = '0, m_key = '0;
    bit         m_clr = 0;

    scan_latch_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                        .led_sink(led_sink), .key_drive(key_drive));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: drive on the falling edge, push the model's state after the next rise
    task automatic step(input bit we, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        if (m_clr) begin
            m_led = '0; m_key = '0; m_clr = 0;
        end else if (we) begin
            m_key[d[2:0]] = d[3];
            m_led[d[6:4]] = d[7];
            if (d[2:0] == 3'd7 && d[3]) m_clr = 1;
        end
        e.led = m_led; e.key = m_key; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (led_sink !== e.led || key_drive !== e.key) begin
                    errors++;
                    $display("FAIL %s: led=%h key=%h expected led=%h key=%h",
                             e.tag, led_sink, key_drive, e.led, e.key);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(3*CLK_PERIOD + 2);
        checks++;
        // R1 reset state
        if (led_sink !== 8'h00 || key_drive !== 8'h00) begin
            errors++;
            $display("FAIL R1: led=%h key=%h expected led=00 key=00", led_sink, key_drive);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3 single-bit updates on both banks
        step(1, 8'h98, "R2_R3 led1 key0 set");
        step(1, 8'hDB, "R2_R3 led5 key3 set");
        step(1, 8'hAE, "R2_R3 led2 key6 set");
        // R5 hold with no strobe
        step(0, 8'hFF, "R5 idle hold");
        step(0, 8'h0F, "R5 idle hold clear pattern");
        // R4 clearing one bit keeps the rest
        step(1, 8'h53, "R4 led5 key3 cleared, others kept");
        step(1, 8'hC9, "R4 led4 key1 set");
        // R8 LED top output, no clear
        step(1, 8'hF0, "R8 led7 set key0 cleared");
        step(0, 8'h00, "R8 no clear follows");
        // R9 switch address 7 with data 0
        step(1, 8'h97, "R9 key7 low, no clear");
        step(0, 8'h00, "R9 state held");
        // R6 self-clear, then R7 write during clearing cycle
        step(1, 8'hEF, "R6 key7 pulse high, led6 set");
        step(1, 8'hFE, "R7 write ignored during clear");
        step(0, 8'h00, "R7 stays clear");
        // Rebuild and clear again via plain 0x0F with idle following
        step(1, 8'hBD, "R2_R3 led3 key5 set");
        step(1, 8'h0F, "R6 key7 high");
        step(0, 8'h00, "R6 all outputs cleared");
        step(0, 8'h00, "R5 hold after clear");
        // Sweep every address on both banks
        for (int i = 0; i < 8; i++)
            step(1, {1'b1, 3'(i), 1'b1, 3'(7 - i)}, "R2_R3 sweep");
        step(0, 8'h00, "R6 sweep tail");
        step(0, 8'h00, "R5 sweep hold");
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule